// File: doc/BRIEF.md
# Single-Precision to Reduced-Float Converter

This block turns an IEEE-754 single-precision bit pattern into a narrower floating-point code. The mantissa width, exponent width and presence of a sign bit are fixed when the block is built. The resulting code is shifted so that its least significant mantissa bit sits at a chosen bit offset of a 32-bit output word, and every other bit of that word is zero. Several converters with different offsets can be OR-ed together to build packed formats, for example three unsigned colour channels in one word. The default build (10 mantissa bits, 5 exponent bits, sign, offset 0) gives standard half precision in the low 16 bits.

Rounding is always toward zero. A finite value too large for the target becomes the largest finite code, not infinity. A value too small for a normal code becomes a target denormal, or zero. Infinities and NaNs keep their class. With the sign bit disabled, every negative value, including negative infinity, becomes zero, and every NaN becomes a positive NaN.

The conversion is combinational. An output register can be built in, which adds one cycle of latency. In that case the output word is loaded only on strobe cycles.

Top module: `f32_to_small`

## Requirements
- R1: For a normal input whose rebiased exponent t = e - 127 + (2^(EXP_W-1) - 1) lies in 1 .. 2^EXP_W - 2, the exponent field is t and the mantissa field is the top MANT_W fraction bits of the input, truncated with no rounding increment.
- R2: A finite input with t >= 2^EXP_W - 1 gives exponent field 2^EXP_W - 2 and mantissa field all ones.
- R3: A normal input with t <= 0 gives exponent field 0 and mantissa floor(|x| * 2^(BIAS - 1 + MANT_W)), which is zero when the magnitude is too small.
- R4: An input with exponent 255 and nonzero fraction gives exponent field all ones and a mantissa with only its top bit set.
- R5: An input with exponent 255 and zero fraction gives exponent field all ones and mantissa zero.
- R6: With HAS_SIGN = 0, any input with bit 31 set that is not a NaN gives an all-zero word. This includes -0 and negative infinity.
- R7: With HAS_SIGN = 1, the magnitude is encoded as in R1 to R5 and R9, and input bit 31 is placed at field bit MANT_W + EXP_W, directly above the exponent. This holds for infinities and NaNs too.
- R8: The field {sign if present, exponent, mantissa} is shifted left by LSB_POS, and all word bits outside the field are zero.
- R9: An input with exponent 0 (zero or single-precision denormal) gives a zero magnitude code.
- R10: With OUT_REG = 1, out_valid equals in_valid one cycle later, and out_word carries the conversion of the strobed input one cycle later. With OUT_REG = 0, both outputs follow the inputs in the same cycle.
- R11: With OUT_REG = 1, out_word keeps its value in every cycle where in_valid is low.
- R12: During reset, out_valid and out_word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking a valid input value |
| in_bits | input | 32 | Single-precision bit pattern to convert |
| out_valid | output | 1 | Valid flag for out_word |
| out_word | output | 32 | Placed reduced-float code, zeros elsewhere |

## Verification
The hardest inputs to reach are those at the rim of the target range. These are the exponents that just overflow to the clamp value, and the long run of exponents below the normal range. In that run the denormal mantissa shrinks one bit per step until it reaches zero. The bench sweeps every one of the 256 input exponents, with both signs and a fixed set of fraction patterns that includes all-ones, a single low bit and alternating bits. It does this on the signed half-precision build and on an unsigned 6/5 build placed at offset 11 with no output register. Expected words are computed from the real value of each input, scaled by powers of two.

// File: rtl/sf_pkg.sv
package sf_pkg;

  typedef enum logic [1:0] {
    SFK_ZERO = 2'd0,
    SFK_NORM = 2'd1,
    SFK_INF  = 2'd2,
    SFK_NAN  = 2'd3
  } sf_kind_e;

  // class of a single-precision pattern from its exponent and fraction
  function automatic sf_kind_e f32_kind(logic [7:0] e, logic [22:0] frac);
    if (e == 8'hFF) return (frac != '0) ? SFK_NAN : SFK_INF;
    if (e == 8'h00) return SFK_ZERO;
    return SFK_NORM;
  endfunction

endpackage

// File: rtl/sf_classify.sv
module sf_classify
  import sf_pkg::*;
(
  input  logic [31:0] bits_i,
  output logic        sign_o,
  output logic [7:0]  exp_o,
  output logic [22:0] frac_o,
  output sf_kind_e    kind_o,
  output logic        is_nan_o,
  output logic        is_inf_o
);

  assign sign_o   = bits_i[31];
  assign exp_o    = bits_i[30:23];
  assign frac_o   = bits_i[22:0];
  assign kind_o   = f32_kind(exp_o, frac_o);
  assign is_nan_o = (kind_o == SFK_NAN);
  assign is_inf_o = (kind_o == SFK_INF);

endmodule

// File: rtl/sf_encode.sv
module sf_encode
  import sf_pkg::*;
#(
  parameter int MANT_W = 10,
  parameter int EXP_W  = 5
) (
  input  sf_kind_e                  kind_i,
  input  logic [7:0]                exp_i,
  input  logic [22:0]               frac_i,
  output logic [EXP_W+MANT_W-1:0]   mag_o,
  output logic                      ovf_evt_o,
  output logic                      sub_evt_o
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam logic [EXP_W-1:0]  EXP_ONES  = '1;
  localparam logic [EXP_W-1:0]  EXP_TOP   = EXP_W'(EMAX - 1);
  localparam logic [MANT_W-1:0] MANT_ONES = '1;
  localparam logic [MANT_W-1:0] MANT_QNAN = MANT_W'(1) << (MANT_W - 1);

  // exponent rebias done on integers
  function automatic int target_exp(logic [7:0] e);
    return int'(e) - 127 + BIAS;
  endfunction

  // denormal mantissa: hidden-one significand shifted right, truncated
  function automatic logic [MANT_W-1:0] denorm_mant(logic [22:0] frac, int t);
    int          sh;
    logic [23:0] sig;
    sh  = 24 - MANT_W - t;
    sig = {1'b1, frac};
    if (sh >= 24) return '0;
    return MANT_W'(sig >> sh);
  endfunction

  int t_exp;

  always_comb begin
    t_exp     = target_exp(exp_i);
    mag_o     = '0;
    ovf_evt_o = 1'b0;
    sub_evt_o = 1'b0;
    case (kind_i)
      SFK_NAN:  mag_o = {EXP_ONES, MANT_QNAN};
      SFK_INF:  mag_o = {EXP_ONES, {MANT_W{1'b0}}};
      SFK_ZERO: mag_o = '0;
      default: begin
        if (t_exp >= EMAX) begin
          ovf_evt_o = 1'b1;
          mag_o     = {EXP_TOP, MANT_ONES};
        end else if (t_exp >= 1) begin
          mag_o = {EXP_W'(t_exp), frac_i[22 -: MANT_W]};
        end else begin
          sub_evt_o = 1'b1;
          mag_o     = {{EXP_W{1'b0}}, denorm_mant(frac_i, t_exp)};
        end
      end
    endcase
  end

endmodule

// File: rtl/sf_place.sv
module sf_place #(
  parameter int MANT_W   = 10,
  parameter int EXP_W    = 5,
  parameter bit HAS_SIGN = 1'b1,
  parameter int LSB_POS  = 0
) (
  input  logic                    sign_i,
  input  logic                    kill_i,
  input  logic [EXP_W+MANT_W-1:0] mag_i,
  output logic [31:0]             word_o
);

  localparam int CW = EXP_W + MANT_W;
  localparam int FW = CW + (HAS_SIGN ? 1 : 0);

  logic [FW-1:0] field;

  generate
    if (HAS_SIGN) begin : g_signed
      assign field = kill_i ? '0 : {sign_i, mag_i};
    end else begin : g_unsigned
      logic unused_sign;
      assign unused_sign = sign_i;
      assign field = kill_i ? '0 : mag_i;
    end
  endgenerate

  assign word_o = {{(32 - FW){1'b0}}, field} << LSB_POS;

endmodule

// File: rtl/f32_to_small.sv
module f32_to_small
  import sf_pkg::*;
#(
  parameter int MANT_W   = 10,
  parameter int EXP_W    = 5,
  parameter bit HAS_SIGN = 1'b1,
  parameter int LSB_POS  = 0,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_bits,
  output logic        out_valid,
  output logic [31:0] out_word
);

  localparam int CW = EXP_W + MANT_W;
  localparam int FW = CW + (HAS_SIGN ? 1 : 0);
  localparam logic [31:0] FIELD_MASK = ((32'd1 << FW) - 32'd1) << LSB_POS;

  logic          in_sign;
  logic [7:0]    in_exp;
  logic [22:0]   in_frac;
  sf_kind_e      in_kind;
  logic          nan_evt;
  logic          inf_evt;
  logic          ovf_evt;
  logic          sub_evt;
  logic          neg_kill;
  logic [CW-1:0] mag_code;
  logic [31:0]   conv_word;

  sf_classify u_cls (
    .bits_i   (in_bits),
    .sign_o   (in_sign),
    .exp_o    (in_exp),
    .frac_o   (in_frac),
    .kind_o   (in_kind),
    .is_nan_o (nan_evt),
    .is_inf_o (inf_evt)
  );

  sf_encode #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_enc (
    .kind_i    (in_kind),
    .exp_i     (in_exp),
    .frac_i    (in_frac),
    .mag_o     (mag_code),
    .ovf_evt_o (ovf_evt),
    .sub_evt_o (sub_evt)
  );

  // unsigned target: negatives (not NaN) collapse to zero
  assign neg_kill = !HAS_SIGN && in_sign && !nan_evt;

  sf_place #(.MANT_W(MANT_W), .EXP_W(EXP_W), .HAS_SIGN(HAS_SIGN),
             .LSB_POS(LSB_POS)) u_place (
    .sign_i (in_sign),
    .kill_i (neg_kill),
    .mag_i  (mag_code),
    .word_o (conv_word)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [31:0] out_field;
      assign out_field = out_word >> LSB_POS;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          out_word  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_word <= conv_word;
        end
      end

      assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));
      assert_outside_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_word & ~FIELD_MASK) == 32'd0));
      assert_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && nan_evt) |=>
          (&out_field[MANT_W +: EXP_W]) && out_field[MANT_W-1]);
      assert_inf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inf_evt && !neg_kill) |=>
          (&out_field[MANT_W +: EXP_W]) && (out_field[MANT_W-1:0] == '0));
      assert_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ovf_evt && !neg_kill) |=>
          (out_field[MANT_W +: EXP_W] == EXP_W'((1 << EXP_W) - 2)) &&
          (&out_field[MANT_W-1:0]));
      assert_denorm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sub_evt) |=> (out_field[MANT_W +: EXP_W] == '0));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_word  = conv_word;
    end
  endgenerate

endmodule

// File: tb/f32_to_small_test.sv
`timescale 1ns/1ps
module f32_to_small_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_bits = '0;
  logic        out_valid, out_valid_u;
  logic [31:0] out_word, out_word_u;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  // signed half precision, registered
  f32_to_small #(.MANT_W(10), .EXP_W(5), .HAS_SIGN(1'b1), .LSB_POS(0),
                 .OUT_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .out_valid(out_valid), .out_word(out_word));

  // unsigned 6/5 placed at bit 11, combinational
  f32_to_small #(.MANT_W(6), .EXP_W(5), .HAS_SIGN(1'b0), .LSB_POS(11),
                 .OUT_REG(1'b0)) uut_u (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .out_valid(out_valid_u), .out_word(out_word_u));

  function automatic real pow2(int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else        for (int i = 0; i < -n; i++) r = r / 2.0;
    return r;
  endfunction

  // expected word from the real value of the input
  function automatic logic [31:0] ref_word(logic [31:0] b, int m, int e, bit s, int l);
    int          ex   = int'(b[30:23]);
    int          bias = (1 << (e - 1)) - 1;
    logic [31:0] code;
    bit          nan  = (ex == 255) && (b[22:0] != 0);
    real         v;
    if (ex == 255) begin
      code = 32'((1 << e) - 1) << m;
      if (nan) code = code | (32'd1 << (m - 1));
    end else if (ex == 0) begin
      code = '0;
    end else begin
      v = (8388608.0 + real'(b[22:0])) * pow2(ex - 150);
      if (v >= pow2((1 << e) - 1 - bias)) begin
        code = (32'((1 << e) - 2) << m) | 32'((1 << m) - 1);
      end else if (v < pow2(1 - bias)) begin
        code = 32'($rtoi(v * pow2(bias - 1 + m)));
      end else begin
        int t = 1;
        while (v >= pow2(t - bias + 1)) t++;
        code = (32'(t) << m) | 32'($rtoi((v / pow2(t - bias) - 1.0) * pow2(m)));
      end
    end
    if (s) code = code | (32'(b[31]) << (m + e));
    else if (b[31] && !nan) code = '0;
    return code << l;
  endfunction

  function automatic string ref_tag(logic [31:0] b, int m, int e, bit s);
    int  ex   = int'(b[30:23]);
    int  bias = (1 << (e - 1)) - 1;
    int  t    = ex - 127 + bias;
    if (ex == 255 && b[22:0] != 0) return "R4";
    if (!s && b[31]) return "R6";
    if (ex == 255) return "R5";
    if (ex == 0) return "R9";
    if (s && b[31]) return "R7";
    if (t >= (1 << e) - 1) return "R2";
    if (t <= 0) return "R3";
    return "R1";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp_v, logic [31:0] inp);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s in=%h actual=%h expected=%h", tag, inp, act, exp_v);
    end
  endtask

  // drive one strobe, check combinational unit now, registered unit next cycle
  task automatic apply(logic [31:0] b);
    @(negedge clk);
    in_bits  = b;
    in_valid = 1'b1;
    #1;
    check(ref_tag(b, 6, 5, 1'b0), out_word_u, ref_word(b, 6, 5, 1'b0, 11), b);
    check("R8", out_word_u & ~(32'h7FF << 11), 32'd0, b);
    check("R10", {31'd0, out_valid_u}, 32'd1, b);
    @(negedge clk);
    in_valid = 1'b0;
    check(ref_tag(b, 10, 5, 1'b1), out_word, ref_word(b, 10, 5, 1'b1, 0), b);
    check("R10", {31'd0, out_valid}, 32'd1, b);
  endtask

  initial begin
    logic [22:0] fr [8];
    logic [31:0] held;
    fr[0] = 23'h000000; fr[1] = 23'h000001; fr[2] = 23'h400000; fr[3] = 23'h7FFFFF;
    fr[4] = 23'h2AAAAA; fr[5] = 23'h155555; fr[6] = 23'h001FFF; fr[7] = 23'h7FE000;

    repeat (3) @(negedge clk);
    check("R12", {31'd0, out_valid}, 32'd0, 32'd0);
    check("R12", out_word, 32'd0, 32'd0);
    rst_n = 1'b1;

    // directed corners: 1.0, 65504, 65520 (clamp), smallest half denormal, -inf, NaNs, -0
    apply(32'h3F800000);
    apply(32'h477FE000);
    apply(32'h477FF000);
    apply(32'h33800000);
    apply(32'h337FFFFF);
    apply(32'hFF800000);
    apply(32'h7F800001);
    apply(32'hFFC00000);
    apply(32'h80000000);
    apply(32'h00000001);

    // full exponent sweep, both signs, fixed fraction patterns
    for (int ex = 0; ex < 256; ex++)
      for (int sg = 0; sg < 2; sg++)
        for (int k = 0; k < 8; k++)
          apply({sg[0], ex[7:0], fr[k]});

    // R10/R11: idle strobe, value held while in_valid is low
    held = out_word;
    @(negedge clk);
    in_bits = 32'h40490FDB;
    @(negedge clk);
    check("R10", {31'd0, out_valid}, 32'd0, in_bits);
    check("R11", out_word, held, in_bits);
    check("R10", {31'd0, out_valid_u}, 32'd0, in_bits);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule